// File: doc/BRIEF.md
# Destination-to-Cube Coalescing Unit

This unit takes an ascending list of destination addresses and shrinks it into a shorter ordered list of cubes. A cube is an address pattern in which each digit is 0, 1 or "don't care". Addresses are loaded one per clock as single-address cubes. The unit then runs scan passes over its internal list. Each pass walks the list from left to right and fuses a neighbouring pair when both cubes have the same don't-care positions and their values differ in exactly one other digit. After a fusion the scan skips past both entries. Passes continue until one pass leaves the list length unchanged. The final list is then streamed out as value and mask pairs, one per clock, together with the number of cubes.

A multicast header generator would use the result to describe a destination set with fewer cube headers. Each cube is a value word plus a mask word, and a mask bit of 1 marks a don't-care digit. Every pass handles one list position per clock and writes into the other half of a ping-pong pair of list stores.

Top module: `cube_coalescer`

## Requirements
- R1: While idle, an `inValid` beat starts a new list with `inAddr` as its first entry, stored with a zero mask. Each further `inValid` beat appends one entry. A beat with `inLast` high ends loading. `busy` is high from the clock after the first accepted beat until the final list is ready.
- R2: Two neighbouring cubes fuse when their masks are equal and their values differ in exactly one unmasked bit. The fused cube has that bit set in its mask and cleared in its value, and keeps the lower cube's other bits.
- R3: Neighbours whose masks differ, and so cover different numbers of addresses, never fuse.
- R4: A pass is a greedy left-to-right scan with a position index starting at 1. After a fusion the index advances by 2. Otherwise the entry to the left is copied unchanged and the index advances by 1.
- R5: An entry left unpaired at the end of a pass is copied into the next list unchanged.
- R6: Passes repeat until a pass produces a list of the same length as its input. In the final list, no two neighbours satisfy the fusion test of R2.
- R7: Output cubes come out in strictly ascending order of the lowest address each one covers. Value bits under set mask bits are always 0.
- R8: The final list comes out on consecutive clocks with `outValid` high, `outLast` high on the last entry, `outCount` equal to the number of cubes and stable throughout, and `busy` low.
- R9: Beats beyond MAX_ENT entries in one list are dropped. A dropped beat that carries `inLast` still ends loading.
- R10: Input beats offered while `busy` or `outValid` is high are ignored and do not change the result.
- R11: After reset, `busy`, `outValid` and `outCount` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Address beat present |
| inLast | input | 1 | Marks the final address beat of a list |
| inAddr | input | ADDR_W | Destination address, ascending across beats |
| busy | output | 1 | Loading or scanning in progress |
| outValid | output | 1 | An output cube is presented |
| outLast | output | 1 | The presented cube is the final one |
| outValue | output | ADDR_W | Cube value, with 0 in don't-care positions |
| outMask | output | ADDR_W | Cube mask, 1 marks a don't-care digit |
| outCount | output | $clog2(MAX_ENT+2) | Number of cubes in the final list |

## Verification
The main instance uses 4-bit addresses and a 16-entry list. With these values the whole address space fits in one list, so a full set can collapse through five passes to a single all-don't-care cube. Smaller sets cover fusion on each bit position, mismatched masks, skip-after-fusion and an unpaired tail. A second instance uses 5-bit addresses and only 4 entries, so a six-address load really overflows the list. The bench then checks that the dropped tail leaves no trace in the result.

// File: rtl/cube_pkg.sv
package cube_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOAD,
    ST_SCAN,
    ST_UNLOAD
  } cubeState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadWr;    // write an input address into bank 0
    logic scanWr;    // write one entry of the next list
    logic useMerge;  // written entry is the fused pair
    logic rdBank;    // bank holding the current list
  } dpStrobe_t;

endpackage

// File: rtl/cube_adjacent.sv
module cube_adjacent #(
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] loValue,
  input  logic [ADDR_W-1:0] loMask,
  input  logic [ADDR_W-1:0] hiValue,
  input  logic [ADDR_W-1:0] hiMask,
  output logic              related,
  output logic [ADDR_W-1:0] mergedValue,
  output logic [ADDR_W-1:0] mergedMask
);

  logic [ADDR_W-1:0] diffBits;
  logic              singleDiff;

  assign diffBits    = (loValue ^ hiValue) & ~loMask;
  assign singleDiff  = (diffBits != '0) && ((diffBits & (diffBits - 1'b1)) == '0);
  assign related     = (loMask == hiMask) && singleDiff;
  assign mergedValue = loValue & ~diffBits;
  assign mergedMask  = loMask | diffBits;

endmodule

// File: rtl/cube_coalesce_dp.sv
module cube_coalesce_dp
  import cube_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int MAX_ENT = 16,
  parameter int CNT_W   = 5
) (
  input  logic              clk,
  input  dpStrobe_t         stb,
  input  logic [CNT_W-1:0]  loadIdx,
  input  logic [ADDR_W-1:0] loadValue,
  input  logic [CNT_W-1:0]  scanIdx,
  input  logic [CNT_W-1:0]  wrIdx,
  input  logic [CNT_W-1:0]  unloadIdx,
  output logic              related,
  output logic [ADDR_W-1:0] outValue,
  output logic [ADDR_W-1:0] outMask
);

  localparam int PTR_W = (MAX_ENT > 1) ? $clog2(MAX_ENT) : 1;

  logic [CNT_W-1:0] loIdxFull;
  logic [PTR_W-1:0] loPtr, hiPtr, wrPtr, ldPtr, unPtr;

  assign loIdxFull = scanIdx - 1'b1;
  assign loPtr     = loIdxFull[PTR_W-1:0];
  assign hiPtr     = scanIdx[PTR_W-1:0];
  assign wrPtr     = wrIdx[PTR_W-1:0];
  assign ldPtr     = loadIdx[PTR_W-1:0];
  assign unPtr     = unloadIdx[PTR_W-1:0];

  logic [ADDR_W-1:0] bankLoVal [2];
  logic [ADDR_W-1:0] bankLoMsk [2];
  logic [ADDR_W-1:0] bankHiVal [2];
  logic [ADDR_W-1:0] bankHiMsk [2];
  logic [ADDR_W-1:0] bankUnVal [2];
  logic [ADDR_W-1:0] bankUnMsk [2];

  logic [ADDR_W-1:0] loValue, loMask, hiValue, hiMask;
  logic [ADDR_W-1:0] mergedValue, mergedMask;
  logic [ADDR_W-1:0] nextValue, nextMask;

  assign loValue = bankLoVal[stb.rdBank];
  assign loMask  = bankLoMsk[stb.rdBank];
  assign hiValue = bankHiVal[stb.rdBank];
  assign hiMask  = bankHiMsk[stb.rdBank];

  cube_adjacent #(.ADDR_W(ADDR_W)) i_adjacent (
    .loValue    (loValue),
    .loMask     (loMask),
    .hiValue    (hiValue),
    .hiMask     (hiMask),
    .related    (related),
    .mergedValue(mergedValue),
    .mergedMask (mergedMask)
  );

  assign nextValue = stb.useMerge ? mergedValue : loValue;
  assign nextMask  = stb.useMerge ? mergedMask  : loMask;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [ADDR_W-1:0] valMem [MAX_ENT];
    logic [ADDR_W-1:0] mskMem [MAX_ENT];
    logic              wrEn;
    logic [PTR_W-1:0]  wrAt;
    logic [ADDR_W-1:0] wrVal, wrMsk;

    always_comb begin
      wrEn  = 1'b0;
      wrAt  = wrPtr;
      wrVal = nextValue;
      wrMsk = nextMask;
      if ((b == 0) && stb.loadWr) begin
        wrEn  = 1'b1;
        wrAt  = ldPtr;
        wrVal = loadValue;
        wrMsk = '0;
      end else if (stb.scanWr && (stb.rdBank != 1'(b))) begin
        wrEn = 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (wrEn) begin
        valMem[wrAt] <= wrVal;
        mskMem[wrAt] <= wrMsk;
      end
    end

    assign bankLoVal[b] = valMem[loPtr];
    assign bankLoMsk[b] = mskMem[loPtr];
    assign bankHiVal[b] = valMem[hiPtr];
    assign bankHiMsk[b] = mskMem[hiPtr];
    assign bankUnVal[b] = valMem[unPtr];
    assign bankUnMsk[b] = mskMem[unPtr];
  end

  assign outValue = bankUnVal[stb.rdBank];
  assign outMask  = bankUnMsk[stb.rdBank];

endmodule

// File: rtl/cube_coalesce_ctrl.sv
module cube_coalesce_ctrl
  import cube_pkg::*;
#(
  parameter int MAX_ENT = 16,
  parameter int CNT_W   = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             inLast,
  input  logic             related,
  output dpStrobe_t        stb,
  output logic [CNT_W-1:0] loadIdx,
  output logic [CNT_W-1:0] scanIdx,
  output logic [CNT_W-1:0] wrIdx,
  output logic [CNT_W-1:0] unloadIdx,
  output logic [CNT_W-1:0] listLen,
  output logic             busy,
  output logic             outValid,
  output logic             outLast
);

  localparam logic [CNT_W-1:0] CAP = CNT_W'(MAX_ENT);

  cubeState_e       state;
  logic [CNT_W-1:0] lenQ, lQ, mQ, uQ;
  logic             bankQ;

  logic             accepting, loadRoom, atPair, atTail;
  logic [CNT_W-1:0] passLen;

  assign accepting = (state == ST_IDLE) || (state == ST_LOAD);
  assign loadIdx   = (state == ST_IDLE) ? '0 : lenQ;
  assign loadRoom  = loadIdx < CAP;
  assign atPair    = (state == ST_SCAN) && (lQ < lenQ);
  assign atTail    = (state == ST_SCAN) && (lQ == lenQ);
  assign passLen   = atTail ? mQ + 1'b1 : mQ;

  always_comb begin
    stb          = '0;
    stb.loadWr   = accepting && inValid && loadRoom;
    stb.scanWr   = atPair || atTail;
    stb.useMerge = atPair && related;
    stb.rdBank   = bankQ;
  end

  assign scanIdx   = lQ;
  assign wrIdx     = mQ;
  assign unloadIdx = uQ;
  assign listLen   = lenQ;
  assign busy      = (state == ST_LOAD) || (state == ST_SCAN);
  assign outValid  = (state == ST_UNLOAD);
  assign outLast   = (state == ST_UNLOAD) && (uQ == lenQ - 1'b1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      lenQ  <= '0;
      lQ    <= '0;
      mQ    <= '0;
      uQ    <= '0;
      bankQ <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (inValid) begin
            lenQ  <= CNT_W'(1);
            bankQ <= 1'b0;
            lQ    <= CNT_W'(1);
            mQ    <= '0;
            state <= inLast ? ST_SCAN : ST_LOAD;
          end
        end
        ST_LOAD: begin
          if (inValid) begin
            if (loadRoom) lenQ <= lenQ + 1'b1;
            if (inLast)   state <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          if (atPair) begin
            mQ <= mQ + 1'b1;
            lQ <= related ? lQ + CNT_W'(2) : lQ + 1'b1;
          end else begin
            lenQ  <= passLen;
            bankQ <= ~bankQ;
            lQ    <= CNT_W'(1);
            mQ    <= '0;
            if (passLen == lenQ) begin
              uQ    <= '0;
              state <= ST_UNLOAD;
            end
          end
        end
        ST_UNLOAD: begin
          uQ <= uQ + 1'b1;
          if (outLast) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cube_coalescer.sv
module cube_coalescer
  import cube_pkg::*;
#(
  parameter  int ADDR_W  = 4,
  parameter  int MAX_ENT = 16,
  localparam int CNT_W   = $clog2(MAX_ENT + 2)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              inLast,
  input  logic [ADDR_W-1:0] inAddr,
  output logic              busy,
  output logic              outValid,
  output logic              outLast,
  output logic [ADDR_W-1:0] outValue,
  output logic [ADDR_W-1:0] outMask,
  output logic [CNT_W-1:0]  outCount
);

  dpStrobe_t        stb;
  logic             related;
  logic [CNT_W-1:0] loadIdx, scanIdx, wrIdx, unloadIdx;

  cube_coalesce_ctrl #(.MAX_ENT(MAX_ENT), .CNT_W(CNT_W)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inLast   (inLast),
    .related  (related),
    .stb      (stb),
    .loadIdx  (loadIdx),
    .scanIdx  (scanIdx),
    .wrIdx    (wrIdx),
    .unloadIdx(unloadIdx),
    .listLen  (outCount),
    .busy     (busy),
    .outValid (outValid),
    .outLast  (outLast)
  );

  cube_coalesce_dp #(.ADDR_W(ADDR_W), .MAX_ENT(MAX_ENT), .CNT_W(CNT_W)) i_dp (
    .clk      (clk),
    .stb      (stb),
    .loadIdx  (loadIdx),
    .loadValue(inAddr),
    .scanIdx  (scanIdx),
    .wrIdx    (wrIdx),
    .unloadIdx(unloadIdx),
    .related  (related),
    .outValue (outValue),
    .outMask  (outMask)
  );

endmodule

// File: rtl/cube_coalescer_chk.sv
module cube_coalescer_chk #(
  parameter  int ADDR_W  = 4,
  parameter  int MAX_ENT = 16,
  localparam int CNT_W   = $clog2(MAX_ENT + 2)
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              outValid,
  input logic              outLast,
  input logic [ADDR_W-1:0] outValue,
  input logic [ADDR_W-1:0] outMask,
  input logic [CNT_W-1:0]  outCount
);

  p_busy_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !busy);

  p_last_in_stream_r8: assert property (@(posedge clk) disable iff (!rstN)
    outLast |-> outValid);

  p_stream_contig_r8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outLast) |=> outValid);

  p_count_stable_r8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outLast) |=> $stable(outCount));

  p_count_range_r9: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outCount >= 1 && outCount <= CNT_W'(MAX_ENT)));

  p_masked_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> ((outValue & outMask) == '0));

  p_ascending_r7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(outValid)) |-> (outValue > $past(outValue)));

  p_no_adjacent_left_r6: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(outValid) && (outMask == $past(outMask)))
      |-> ($countones((outValue ^ $past(outValue)) & ~outMask) != 1));

endmodule

bind cube_coalescer cube_coalescer_chk #(.ADDR_W(ADDR_W), .MAX_ENT(MAX_ENT)) i_chk (
  .clk     (clk),
  .rstN    (rstN),
  .busy    (busy),
  .outValid(outValid),
  .outLast (outLast),
  .outValue(outValue),
  .outMask (outMask),
  .outCount(outCount)
);

// File: tb/test_cube_coalescer.sv
module test_cube_coalescer;

  localparam int ADDR_W  = 4;
  localparam int MAX_ENT = 16;
  localparam int CNT_W   = $clog2(MAX_ENT + 2);
  localparam int NVEC    = 12;

  // input set as a 16-bit membership map; expected cubes packed as bytes
  // {value[3:0], mask[3:0]}, cube k in bits [8k+7:8k]
  localparam logic [15:0] VEC_SET [NVEC] = '{
    16'h2AD8, 16'hFFFF, 16'h001F, 16'h000E, 16'h0020, 16'h0505,
    16'h0007, 16'h0009, 16'h0116, 16'hF0F0, 16'h008A, 16'hC0C8};
  localparam int VEC_CNT [NVEC] = '{5, 1, 2, 2, 1, 1, 2, 2, 4, 1, 2, 2};
  localparam logic [63:0] VEC_EXP [NVEC] = '{
    64'h000000D092704230, 64'h0F, 64'h4003, 64'h2110, 64'h50, 64'h0A,
    64'h2001, 64'h3000, 64'h80402010, 64'h4B, 64'h7012, 64'h6930};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic              inValid = 1'b0, inLast = 1'b0;
  logic [ADDR_W-1:0] inAddr = '0;
  logic              busy, outValid, outLast;
  logic [ADDR_W-1:0] outValue, outMask;
  logic [CNT_W-1:0]  outCount;

  cube_coalescer #(.ADDR_W(ADDR_W), .MAX_ENT(MAX_ENT)) i_cube_coalescer (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inLast(inLast), .inAddr(inAddr),
    .busy(busy), .outValid(outValid), .outLast(outLast),
    .outValue(outValue), .outMask(outMask), .outCount(outCount));

  logic       capValid = 1'b0, capLast = 1'b0;
  logic [4:0] capAddr = '0;
  logic       capBusy, capOutValid, capOutLast;
  logic [4:0] capValue, capMask;
  logic [2:0] capCount;

  cube_coalescer #(.ADDR_W(5), .MAX_ENT(4)) i_cube_coalescer_cap (
    .clk(clk), .rstN(rstN), .inValid(capValid), .inLast(capLast), .inAddr(capAddr),
    .busy(capBusy), .outValid(capOutValid), .outLast(capOutLast),
    .outValue(capValue), .outMask(capMask), .outCount(capCount));

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic string vecTag(int v);
    case (v)
      0, 9:  return "R6";
      1:     return "R6";
      2, 3:  return "R4";
      4, 10: return "R5";
      5, 7:  return "R2";
      6, 11: return "R3";
      default: return "R2";
    endcase
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", cycles, 100000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic runVec(int v);
    int top = -1;
    int got = 0;
    int junk = 0;
    bit done = 0;
    logic [7:0] expByte;
    for (int a = 0; a < 16; a++) if (VEC_SET[v][a]) top = a;
    for (int a = 0; a < 16; a++) begin
      if (VEC_SET[v][a]) begin
        @(negedge clk);
        inValid = 1'b1;
        inAddr  = ADDR_W'(a);
        inLast  = (a == top);
      end
    end
    @(negedge clk);
    inValid = 1'b0;
    inLast  = 1'b0;
    check(busy == 1'b1, "R1", $sformatf("vec %0d busy after load", v), int'(busy), 1);
    for (int t = 0; t < 400 && !done; t++) begin
      if (outValid) begin
        expByte = VEC_EXP[v][8*got +: 8];
        check(outValue == expByte[7:4], vecTag(v), $sformatf("vec %0d cube %0d value", v, got),
              int'(outValue), int'(expByte[7:4]));
        check(outMask == expByte[3:0], vecTag(v), $sformatf("vec %0d cube %0d mask", v, got),
              int'(outMask), int'(expByte[3:0]));
        check(int'(outCount) == VEC_CNT[v], "R8", $sformatf("vec %0d outCount", v),
              int'(outCount), VEC_CNT[v]);
        got++;
        if (outLast) begin
          done = 1;
          check(got == VEC_CNT[v], "R8", $sformatf("vec %0d outLast position", v), got, VEC_CNT[v]);
        end
      end
      // R10: offer a bogus beat while busy
      if (!done && busy && junk < 2) begin
        inValid = 1'b1;
        inAddr  = '1;
        inLast  = 1'b1;
        junk++;
      end else begin
        inValid = 1'b0;
        inLast  = 1'b0;
      end
      @(negedge clk);
    end
    inValid = 1'b0;
    inLast  = 1'b0;
    check(got == VEC_CNT[v], "R10", $sformatf("vec %0d cube count", v), got, VEC_CNT[v]);
    check(!outValid && !busy, "R8", $sformatf("vec %0d idle after stream", v),
          int'({outValid, busy}), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R11", "busy in reset", int'(busy), 0);
    check(outValid == 1'b0, "R11", "outValid in reset", int'(outValid), 0);
    check(outCount == '0, "R11", "outCount in reset", int'(outCount), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(busy == 1'b0 && outValid == 1'b0, "R11", "idle after reset",
          int'({busy, outValid}), 0);

    for (int v = 0; v < NVEC; v++) runVec(v);

    // R9: six beats into a four-entry list; only 0..3 are kept -> 000xx
    for (int a = 0; a < 6; a++) begin
      @(negedge clk);
      capValid = 1'b1;
      capAddr  = 5'(a);
      capLast  = (a == 5);
    end
    @(negedge clk);
    capValid = 1'b0;
    capLast  = 1'b0;
    begin
      int capGot = 0;
      bit capDone = 0;
      for (int t = 0; t < 200 && !capDone; t++) begin
        if (capOutValid) begin
          check(capValue == 5'd0, "R9", "capped list value", int'(capValue), 0);
          check(capMask == 5'd3, "R9", "capped list mask", int'(capMask), 3);
          check(capCount == 3'd1, "R9", "capped list count", int'(capCount), 1);
          capGot++;
          if (capOutLast) capDone = 1;
        end
        @(negedge clk);
      end
      check(capGot == 1, "R9", "capped cubes streamed", capGot, 1);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule